// File: doc/BRIEF.md
# Single-Clock Fall-Through Queue

This block is a first-in first-out queue for one clock domain. Its words are held in a memory whose read port is registered, so a plain read returns data one cycle late. A small prefetch state machine hides that latency. As soon as a word is stored, the machine fetches it into the output register without any request from the consumer. The consumer therefore sees the oldest word on `rd_data` whenever `empty` is low. It takes that word by pulsing `rd_ack`, and the next word is then presented in the following cycle.

`empty` falls a fixed number of cycles after the first word is written. It does not wait for the write burst to end, so a producer that streams many words back to back does not hold back the consumer. All read-side activity is qualified by `rd_ce`. An asynchronous `init` clears the pointers and returns the prefetch machine to its idle state.

The prefetch machine has three states:
- IDLE: nothing is held and `empty` is high. Leaving IDLE for FETCH needs `rd_ce` high and a non-empty store, and this transition fires the automatic internal read.
- FETCH: the fetched word lands in the output register. `empty` is still high. With `rd_ce` high, the machine moves on to VALID.
- VALID: `empty` is low. An enabled `rd_ack` while the store still holds words fires an internal read and the machine stays in VALID. An enabled `rd_ack` while the store is empty sends the machine back to IDLE.

Top module: `fwft_fifo`

## Requirements
- R1: While `init` is high, `empty` reads 1 and `full` reads 0 without waiting for a clock edge. Any words held before `init` are discarded.
- R2: With `rd_ce` high and the queue empty, a word written in cycle 0 makes `empty` read high after edges 0 and 1 and low after edge 2, with that word on `rd_data`. This timing holds even while further writes continue in every cycle.
- R3: The first word is fetched into the output register by an internal read that needs no `rd_ack`.
- R4: An `rd_ack` taken while `empty` is low and more words are stored puts the next word on `rd_data` after the same edge, and `empty` stays low.
- R5: An `rd_ack` that takes the last word sets `empty` high after that edge. A later write restarts the sequence of R2.
- R6: While `rd_ce` is low, `empty`, `rd_data` and the prefetch state hold, and `rd_ack` has no effect.
- R7: `full` is high exactly when DEPTH words are held, counting the word in the output register. Writes while `full` is high are dropped.
- R8: An `rd_ack` while `empty` is high is ignored and does not disturb later data.
- R9: A write and an enabled `rd_ack` in the same cycle on a queue that is neither empty nor full keep the occupancy unchanged.
- R10: Whenever `empty` is low, `rd_data` holds the oldest word not yet acknowledged, and words leave in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| init | input | 1 | Asynchronous clear, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| full | output | 1 | Queue holds DEPTH words |
| rd_ce | input | 1 | Read-side clock enable |
| rd_ack | input | 1 | Consumer takes the word on rd_data |
| rd_data | output | WIDTH | Oldest word, valid while empty is low |
| empty | output | 1 | No valid word on rd_data |

## Verification
The first word is due on `rd_data` two edges after the edge that writes it, so `empty` is sampled high after the write edge and after the next one, then low after the third. An acknowledge changes `rd_data` or raises `empty` on the very next edge. `full` follows the edge of the write that fills the queue. The bench drives inputs one time unit after each rising edge and samples outputs just after the next edge. Each check is therefore tied to a counted number of edges from its stimulus, including in bursts longer than the depth, where the check falls while writes are still being issued.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

    typedef enum logic [1:0] {
        PF_IDLE  = 2'd0,
        PF_FETCH = 2'd1,
        PF_VALID = 2'd2
    } pf_state_t;

endpackage

// File: rtl/fwft_ram.sv
module fwft_ram #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             init,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read port doubles as the output register.
    always_ff @(posedge clk or posedge init) begin
        if (init) begin
            q <= '0;
        end else if (re) begin
            q <= mem[raddr];
        end
    end

endmodule

// File: rtl/fwft_ptrs.sv
module fwft_ptrs #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          init,
    input  logic          wr_req,
    input  logic          int_rd,
    input  logic          holding,
    output logic          wr_ok,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          store_empty,
    output logic          full,
    output logic [PW-1:0] wptr_q,
    output logic [PW-1:0] occ
);

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] rptr_q;
    logic [PW-1:0] head;

    // Head counts the word already moved into the output register.
    always_comb begin
        head        = rptr_q - {{(PW-1){1'b0}}, holding};
        occ         = wptr_q - head;
        full        = (occ == DEPTH_P);
        store_empty = (wptr_q == rptr_q);
        wr_ok       = wr_req && !full;
        waddr       = wptr_q[AW-1:0];
        raddr       = rptr_q[AW-1:0];
    end

    always_ff @(posedge clk or posedge init) begin
        if (init) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (wr_ok) begin
                wptr_q <= wptr_q + 1'b1;
            end
            if (int_rd) begin
                rptr_q <= rptr_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fwft_prefetch.sv
module fwft_prefetch
    import fwft_pkg::*;
(
    input  logic clk,
    input  logic init,
    input  logic ce,
    input  logic ack,
    input  logic store_empty,
    output logic int_rd,
    output logic empty,
    output logic holding
);

    pf_state_t state_q;
    pf_state_t state_d;

    always_ff @(posedge clk or posedge init) begin
        if (init) begin
            state_q <= PF_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (ce) begin
            unique case (state_q)
                PF_IDLE: begin
                    if (!store_empty) state_d = PF_FETCH;
                end
                PF_FETCH: begin
                    state_d = PF_VALID;
                end
                PF_VALID: begin
                    if (ack && store_empty) state_d = PF_IDLE;
                end
                default: state_d = PF_IDLE;
            endcase
        end
    end

    always_comb begin
        int_rd  = 1'b0;
        empty   = 1'b1;
        holding = 1'b0;
        unique case (state_q)
            PF_IDLE: begin
                int_rd = ce && !store_empty;
            end
            PF_FETCH: begin
                holding = 1'b1;
            end
            PF_VALID: begin
                holding = 1'b1;
                empty   = 1'b0;
                int_rd  = ce && ack && !store_empty;
            end
            default: begin
                int_rd = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             clk,
    input  logic             init,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    input  logic             rd_ce,
    input  logic             rd_ack,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty
);

    logic          wr_ok;
    logic          int_rd;
    logic          holding;
    logic          store_empty;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wptr_q;
    logic [PW-1:0] occ;

    fwft_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk         (clk),
        .init        (init),
        .wr_req      (wr_en),
        .int_rd      (int_rd),
        .holding     (holding),
        .wr_ok       (wr_ok),
        .waddr       (waddr),
        .raddr       (raddr),
        .store_empty (store_empty),
        .full        (full),
        .wptr_q      (wptr_q),
        .occ         (occ)
    );

    fwft_prefetch u_pf (
        .clk         (clk),
        .init        (init),
        .ce          (rd_ce),
        .ack         (rd_ack),
        .store_empty (store_empty),
        .int_rd      (int_rd),
        .empty       (empty),
        .holding     (holding)
    );

    fwft_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .init  (init),
        .we    (wr_ok),
        .waddr (waddr),
        .wdata (wr_data),
        .re    (int_rd),
        .raddr (raddr),
        .q     (rd_data)
    );

endmodule

// File: rtl/fwft_fifo_chk.sv
module fwft_fifo_chk #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             init,
    input logic             wr_en,
    input logic             full,
    input logic             rd_ce,
    input logic             rd_ack,
    input logic [WIDTH-1:0] rd_data,
    input logic             empty,
    input logic             int_rd,
    input logic             store_empty,
    input logic [PW-1:0]    wptr_q,
    input logic [PW-1:0]    occ
);

    // R1
    always_ff @(posedge clk) begin
        if (init) begin
            init_clear_chk: assert (empty && !full);
        end
    end

    // R3
    no_phantom_read_chk: assert property (@(posedge clk) disable iff (init)
        int_rd |-> (!store_empty && rd_ce));

    // R4
    ack_advance_chk: assert property (@(posedge clk) disable iff (init)
        (!empty && rd_ack && rd_ce && !store_empty) |=> !empty);

    // R5
    ack_last_chk: assert property (@(posedge clk) disable iff (init)
        (!empty && rd_ack && rd_ce && store_empty) |=> empty);

    // R6
    ce_hold_chk: assert property (@(posedge clk) disable iff (init)
        !rd_ce |=> ($stable(empty) && $stable(rd_data)));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (init)
        full |=> $stable(wptr_q));

    // R7
    occ_bound_chk: assert property (@(posedge clk) disable iff (init)
        occ <= PW'(DEPTH));

    // R8
    ack_when_empty_chk: assert property (@(posedge clk) disable iff (init)
        (empty && rd_ack && store_empty) |-> !int_rd);

    // R9
    occ_steady_chk: assert property (@(posedge clk) disable iff (init)
        (!empty && !full && wr_en && rd_ack && rd_ce) |=> $stable(occ));

endmodule

bind fwft_fifo fwft_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .init        (init),
    .wr_en       (wr_en),
    .full        (full),
    .rd_ce       (rd_ce),
    .rd_ack      (rd_ack),
    .rd_data     (rd_data),
    .empty       (empty),
    .int_rd      (int_rd),
    .store_empty (store_empty),
    .wptr_q      (wptr_q),
    .occ         (occ)
);

// File: tb/fwft_fifo_bench.sv
module fwft_fifo_bench;

    localparam int WIDTH = 8;
    localparam int DEPTH = 4;

    logic             clk = 1'b0;
    logic             init = 1'b1;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             full;
    logic             rd_ce = 1'b1;
    logic             rd_ack = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic             empty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [WIDTH-1:0] mq [$];

    always #5 clk = ~clk;

    fwft_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fwft_fifo (
        .clk     (clk),
        .init    (init),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .full    (full),
        .rd_ce   (rd_ce),
        .rd_ack  (rd_ack),
        .rd_data (rd_data),
        .empty   (empty)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Acknowledge every modelled word in turn, then expect the queue empty.
    task automatic drain(input string req);
        rd_ack = 1'b1;
        while (mq.size() > 0) begin
            check({req, " R10 empty low"}, {31'd0, empty}, 32'd0);
            check({req, " R10 head data"}, {24'd0, rd_data}, {24'd0, mq[0]});
            tick();
            void'(mq.pop_front());
        end
        rd_ack = 1'b0;
        check({req, " R5 empty after last"}, {31'd0, empty}, 32'd1);
        check({req, " R7 full clear"}, {31'd0, full}, 32'd0);
    endtask

    initial begin
        #3;
        check("R1 empty during init", {31'd0, empty}, 32'd1);
        check("R1 full during init", {31'd0, full}, 32'd0);
        tick();
        init = 1'b0;
        tick();

        // R2 R3 R7: bursts of every length from 1 to DEPTH+2
        for (int n = 1; n <= DEPTH + 2; n++) begin
            for (int k = 0; k < ((n > 3) ? n : 3); k++) begin
                wr_en   = (k < n);
                wr_data = WIDTH'(n * 16 + k);
                if (k < n && k < DEPTH) mq.push_back(WIDTH'(n * 16 + k));
                tick();
                check("R2 empty timing", {31'd0, empty}, {31'd0, (k < 2)});
                if (k >= 2) check("R3 first word shown", {24'd0, rd_data}, {24'd0, mq[0]});
            end
            wr_en = 1'b0;
            check("R7 full after burst", {31'd0, full}, {31'd0, (n >= DEPTH)});
            drain("burst");
        end

        // R8: acknowledge while empty
        rd_ack = 1'b1;
        for (int j = 0; j < 3; j++) begin
            tick();
            check("R8 empty stays high", {31'd0, empty}, 32'd1);
        end
        rd_ack = 1'b0;
        wr_en = 1'b1; wr_data = 8'h3C; mq.push_back(8'h3C);
        tick();
        wr_en = 1'b0;
        tick(); tick();
        check("R8 later word intact", {24'd0, rd_data}, 32'h3C);
        drain("R8");

        // R6: clock enable low holds everything
        rd_ce = 1'b0;
        wr_en = 1'b1; wr_data = 8'hA5;
        tick();
        wr_en = 1'b0;
        for (int j = 0; j < 4; j++) begin
            tick();
            check("R6 no fetch with ce low", {31'd0, empty}, 32'd1);
        end
        rd_ce = 1'b1;
        tick();
        check("R6 fetch stage", {31'd0, empty}, 32'd1);
        tick();
        check("R6 valid after ce", {31'd0, empty}, 32'd0);
        check("R6 data after ce", {24'd0, rd_data}, 32'hA5);
        rd_ce = 1'b0; rd_ack = 1'b1;
        for (int j = 0; j < 3; j++) begin
            tick();
            check("R6 ack held off", {31'd0, empty}, 32'd0);
            check("R6 data held", {24'd0, rd_data}, 32'hA5);
        end
        rd_ce = 1'b1;
        tick();
        rd_ack = 1'b0;
        check("R5 taken with ce", {31'd0, empty}, 32'd1);

        // R9: simultaneous write and acknowledge
        wr_en = 1'b1; wr_data = 8'h11; mq.push_back(8'h11);
        tick();
        wr_data = 8'h22; mq.push_back(8'h22);
        tick();
        wr_en = 1'b0;
        tick();
        for (int j = 0; j < 6; j++) begin
            check("R9 empty low", {31'd0, empty}, 32'd0);
            check("R9 full low", {31'd0, full}, 32'd0);
            check("R9 order", {24'd0, rd_data}, {24'd0, mq[0]});
            wr_en = 1'b1; rd_ack = 1'b1;
            wr_data = WIDTH'(8'h40 + j);
            mq.push_back(WIDTH'(8'h40 + j));
            tick();
            void'(mq.pop_front());
        end
        wr_en = 1'b0; rd_ack = 1'b0;
        check("R9 occupancy kept", mq.size(), 32'd2);
        drain("R9");

        // R1: asynchronous clear mid-run
        wr_en = 1'b1; wr_data = 8'h77;
        tick(); tick(); tick();
        wr_en = 1'b0;
        tick();
        #2 init = 1'b1;
        #1;
        check("R1 async empty", {31'd0, empty}, 32'd1);
        check("R1 async full", {31'd0, full}, 32'd0);
        tick();
        init = 1'b0;
        wr_en = 1'b1; wr_data = 8'h5A; mq.push_back(8'h5A);
        tick();
        wr_en = 1'b0;
        tick(); tick();
        check("R1 old words gone", {24'd0, rd_data}, 32'h5A);
        drain("R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule